// File: doc/BRIEF.md
# Debug Comparator Register Bank with Arm Lock

This block is the register file of an on-chip debug unit. It stores two 16-bit comparator values, A and B. Each value is split into a high byte and a low byte, and each byte has its own address on a byte-wide bus. The block drives both full 16-bit values continuously to the match logic that sits beside it. An arm input from the debug unit freezes the comparators. While the unit is armed, the normal bus can still read every byte, but its writes to the comparators are dropped silently.

A second write path stands in for a serial background debug channel and has privilege over the normal bus. It carries its own address, data and strobe. It is the only way to reach a force-reset control register. Writing a one into the trigger bit of that register through the privileged path raises a one-cycle system reset request. The control register itself always reads as zero, and writes to it from the normal bus change nothing.

Top module: `dbg_regbank`

## Requirements
- R1: While rst_n is low, cmp_a and cmp_b are 0x0000 and sys_rst_req is 0. All four comparator bytes read 0x00 after reset.
- R2: The normal-bus address map is as follows. 0 selects the A high byte (cmp_a[15:8]), 1 the A low byte, 2 the B high byte (cmp_b[15:8]) and 3 the B low byte. bus_rdata is combinational and shows the selected byte in the same cycle, whatever the state of arm_i.
- R3: A normal-bus write (bus_wr=1) to addresses 0 to 3 with arm_i=0 replaces that byte on the next rising edge. cmp_a or cmp_b shows the new byte after that edge, and the other three bytes keep their values.
- R4: While arm_i=1, normal-bus writes to addresses 0 to 3 are ignored, and cmp_a and cmp_b do not change.
- R5: Address 4 is the force-reset control register. It reads 0x00 on bus_rdata at all times.
- R6: A privileged write (dbg_wr=1) to address 4 with dbg_wdata bit 0 set makes sys_rst_req high for exactly the cycle after that edge. Bit 0 clear gives no pulse, and bits 7 to 1 are ignored.
- R7: Normal-bus writes to address 4 never raise sys_rst_req. When both paths write address 4 in the same cycle, only the privileged data decides the outcome.
- R8: Addresses 5 to 15 read 0x00, and normal-bus writes to them leave cmp_a and cmp_b unchanged.
- R9: Privileged writes never change cmp_a or cmp_b, at any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Normal-bus byte address |
| bus_wr | input | 1 | Normal-bus write strobe |
| bus_wdata | input | 8 | Normal-bus write data |
| bus_rdata | output | 8 | Normal-bus read data (combinational) |
| dbg_addr | input | 4 | Privileged-path address |
| dbg_wr | input | 1 | Privileged-path write strobe |
| dbg_wdata | input | 8 | Privileged-path write data |
| arm_i | input | 1 | Debug unit armed; locks the comparators |
| cmp_a | output | 16 | Comparator A value |
| cmp_b | output | 16 | Comparator B value |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check several properties on every cycle. Comparators stay frozen while the unit is armed. Privileged or unmapped writes never move them. The control register and unmapped addresses read zero. The reset request follows each qualifying privileged write and appears at no other time. The bench's scenarios are needed for the rest. They show that each byte lands in the correct half of the correct comparator without disturbing the other bytes, and that reset clears everything. They also show that read data matches the stored bytes across long random runs with the lock toggling, and that simultaneous writes on both paths resolve as required.

// File: rtl/dbg_regbank_pkg.sv
package dbg_regbank_pkg;
  localparam int BYTE_W   = 8;
  localparam int CMP_W    = 16;
  localparam int NUM_CMP  = 2;
  localparam int BPC      = CMP_W / BYTE_W;   // bytes per comparator
  localparam int NSLOT    = NUM_CMP * BPC;    // comparator byte slots
  localparam int ADDR_W   = 4;
  localparam int FRC_ADDR = NSLOT;            // control register follows the slots
  localparam int FRC_BIT  = 0;

  // slot index of byte k (0 = most significant) of comparator c
  function automatic int slot_of(input int c, input int k);
    return c * BPC + k;
  endfunction

  function automatic logic is_frc(input logic [ADDR_W-1:0] a);
    return a == ADDR_W'(FRC_ADDR);
  endfunction

  function automatic logic frc_set(input logic [BYTE_W-1:0] d);
    return d[FRC_BIT];
  endfunction
endpackage

// File: rtl/dbg_addr_decode.sv
module dbg_addr_decode #(
  parameter int AW  = 4,
  parameter int NS  = 4,
  parameter int FRC = 4
) (
  input  logic [AW-1:0] addr,
  output logic [NS-1:0] slot_hit,
  output logic          frc_hit
);
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      slot_hit[s] = (addr == AW'(s));
    end
    frc_hit = (addr == AW'(FRC));
  end
endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank #(
  parameter int BW = 8,
  parameter int NS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NS-1:0]        wr_en,
  input  logic [BW-1:0]        wdata,
  output logic [NS-1:0][BW-1:0] q
);
  for (genvar g = 0; g < NS; g++) begin : g_slot
    logic [BW-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)        r <= '0;
      else if (wr_en[g]) r <= wdata;
    end
    assign q[g] = r;
  end
endmodule

// File: rtl/dbg_force_rst.sv
module dbg_force_rst
  import dbg_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              fire,
  output logic              req
);
  assign fire = wr && is_frc(addr) && frc_set(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= fire;
  end
endmodule

// File: rtl/dbg_regbank.sv
module dbg_regbank
  import dbg_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic              dbg_wr,
  input  logic [BYTE_W-1:0] dbg_wdata,
  input  logic              arm_i,
  output logic [CMP_W-1:0]  cmp_a,
  output logic [CMP_W-1:0]  cmp_b,
  output logic              sys_rst_req
);
  logic [NSLOT-1:0]             slot_hit;
  logic                         bus_frc_hit;
  logic [NSLOT-1:0]             slot_wr;
  logic [NSLOT-1:0][BYTE_W-1:0] slots;

  // named events for the checker
  logic bus_cmp_wr_ok;
  logic bus_frc_wr;
  logic dbg_frc_fire;

  dbg_addr_decode #(.AW(ADDR_W), .NS(NSLOT), .FRC(FRC_ADDR)) u_dec (
    .addr     (bus_addr),
    .slot_hit (slot_hit),
    .frc_hit  (bus_frc_hit)
  );

  assign bus_cmp_wr_ok = bus_wr && !arm_i;
  assign bus_frc_wr    = bus_wr && bus_frc_hit;
  assign slot_wr       = slot_hit & {NSLOT{bus_cmp_wr_ok}};

  dbg_cmp_bank #(.BW(BYTE_W), .NS(NSLOT)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (slot_wr),
    .wdata (bus_wdata),
    .q     (slots)
  );

  // only the privileged path reaches the control register
  dbg_force_rst u_frc (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (dbg_wr),
    .addr  (dbg_addr),
    .wdata (dbg_wdata),
    .fire  (dbg_frc_fire),
    .req   (sys_rst_req)
  );

  // read mux: control register, reserved bits and unmapped space give zero
  always_comb begin
    bus_rdata = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (slot_hit[s]) bus_rdata = slots[s];
    end
  end

  for (genvar k = 0; k < BPC; k++) begin : g_out
    assign cmp_a[CMP_W-1-k*BYTE_W -: BYTE_W] = slots[slot_of(0, k)];
    assign cmp_b[CMP_W-1-k*BYTE_W -: BYTE_W] = slots[slot_of(1, k)];
  end
endmodule

// File: rtl/dbg_regbank_chk.sv
module dbg_regbank_chk
  import dbg_regbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              dbg_wr,
  input logic              arm_i,
  input logic [CMP_W-1:0]  cmp_a,
  input logic [CMP_W-1:0]  cmp_b,
  input logic              sys_rst_req,
  input logic              bus_frc_wr,
  input logic              dbg_frc_fire
);
  a_r3_a_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !arm_i && bus_addr == ADDR_W'(0)) |=> (cmp_a[CMP_W-1 -: BYTE_W] == $past(bus_wdata)));

  a_r3_b_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !arm_i && bus_addr == ADDR_W'(NSLOT-1)) |=> (cmp_b[BYTE_W-1:0] == $past(bus_wdata)));

  a_r4_armed_lock: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> ($stable(cmp_a) && $stable(cmp_b)));

  a_r9_only_bus_moves_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(cmp_a) && $stable(cmp_b)));

  a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(FRC_ADDR)) |=> ($stable(cmp_a) && $stable(cmp_b)));

  a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(FRC_ADDR)) |-> (bus_rdata == '0));

  a_r5_frc_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(FRC_ADDR)) |-> (bus_rdata == '0));

  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_frc_fire |=> sys_rst_req);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_frc_fire |=> !sys_rst_req);

  a_r7_bus_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_frc_wr && !dbg_wr) |=> !sys_rst_req);
endmodule

bind dbg_regbank dbg_regbank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .dbg_wr       (dbg_wr),
  .arm_i        (arm_i),
  .cmp_a        (cmp_a),
  .cmp_b        (cmp_b),
  .sys_rst_req  (sys_rst_req),
  .bus_frc_wr   (bus_frc_wr),
  .dbg_frc_fire (dbg_frc_fire)
);

// File: tb/dbg_regbank_test.sv
module dbg_regbank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] dbg_addr = '0;
  logic       dbg_wr = 1'b0;
  logic [7:0] dbg_wdata = '0;
  logic       arm_i = 1'b0;
  logic [15:0] cmp_a, cmp_b;
  logic        sys_rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] mb [4];   // model: A hi, A lo, B hi, B lo
  logic       m_req;

  always #2 clk = ~clk;

  dbg_regbank uut (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_addr(dbg_addr), .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata),
    .arm_i(arm_i), .cmp_a(cmp_a), .cmp_b(cmp_b), .sys_rst_req(sys_rst_req)
  );

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    if (a < 4) return mb[a];
    return 8'h00;
  endfunction

  function automatic string read_tag(input logic [3:0] a);
    if (a < 4) return "R2";
    if (a == 4) return "R5";
    return "R8";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle at a negedge, check the read, then the registered state
  task automatic step(input logic [3:0] ba, input logic bw, input logic [7:0] bd,
                      input logic [3:0] da, input logic dw, input logic [7:0] dd,
                      input logic arm, input string tag);
    bus_addr = ba; bus_wr = bw; bus_wdata = bd;
    dbg_addr = da; dbg_wr = dw; dbg_wdata = dd; arm_i = arm;
    #1;
    chk(read_tag(ba), {24'h0, bus_rdata}, {24'h0, exp_read(ba)});
    if (bw && !arm && ba < 4) mb[ba] = bd;
    m_req = dw && (da == 4) && dd[0];
    @(negedge clk);
    chk(tag, {16'h0, cmp_a}, {16'h0, mb[0], mb[1]});
    chk(tag, {16'h0, cmp_b}, {16'h0, mb[2], mb[3]});
    chk("R6", {31'h0, sys_rst_req}, {31'h0, m_req});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) mb[i] = 8'h00;
    m_req = 1'b0;
    // R1: hold reset while the bus tries to write
    bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 8'hAA;
    dbg_wr = 1'b1; dbg_addr = 4'd4; dbg_wdata = 8'h01;
    repeat (3) @(negedge clk);
    chk("R1", {16'h0, cmp_a}, 32'h0);
    chk("R1", {16'h0, cmp_b}, 32'h0);
    chk("R1", {31'h0, sys_rst_req}, 32'h0);
    bus_wr = 1'b0; dbg_wr = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R3: fill each byte unlocked
    step(4'd0, 1, 8'h12, 4'd0, 0, 8'h00, 0, "R3");
    step(4'd1, 1, 8'h34, 4'd0, 0, 8'h00, 0, "R3");
    step(4'd2, 1, 8'h56, 4'd0, 0, 8'h00, 0, "R3");
    step(4'd3, 1, 8'h78, 4'd0, 0, 8'h00, 0, "R3");
    chk("R3", {16'h0, cmp_a}, 32'h1234);
    chk("R3", {16'h0, cmp_b}, 32'h5678);
    // R4: armed writes dropped, reads still served
    step(4'd0, 1, 8'hFF, 4'd0, 0, 8'h00, 1, "R4");
    step(4'd3, 1, 8'hEE, 4'd0, 0, 8'h00, 1, "R4");
    chk("R4", {16'h0, cmp_a}, 32'h1234);
    step(4'd0, 0, 8'h00, 4'd0, 0, 8'h00, 1, "R2");
    // R6: privileged trigger; bit 0 clear gives nothing
    step(4'd4, 0, 8'h00, 4'd4, 1, 8'h01, 0, "R6");
    chk("R6", {31'h0, sys_rst_req}, 32'h1);
    step(4'd4, 0, 8'h00, 4'd4, 0, 8'h00, 0, "R6");
    chk("R6", {31'h0, sys_rst_req}, 32'h0);
    step(4'd4, 0, 8'h00, 4'd4, 1, 8'hFE, 0, "R6");
    // R7: normal bus cannot trigger, privileged data wins on overlap
    step(4'd4, 1, 8'hFF, 4'd0, 0, 8'h00, 0, "R7");
    chk("R7", {31'h0, sys_rst_req}, 32'h0);
    step(4'd4, 1, 8'hFF, 4'd4, 1, 8'h00, 0, "R7");
    chk("R7", {31'h0, sys_rst_req}, 32'h0);
    step(4'd4, 1, 8'h00, 4'd4, 1, 8'h01, 0, "R7");
    chk("R7", {31'h0, sys_rst_req}, 32'h1);
    // R8: unmapped writes and reads
    step(4'd9, 1, 8'hC3, 4'd0, 0, 8'h00, 0, "R8");
    step(4'd15, 1, 8'h3C, 4'd0, 0, 8'h00, 0, "R8");
    // R9: privileged writes to comparator addresses
    step(4'd0, 0, 8'h00, 4'd0, 1, 8'h99, 0, "R9");
    step(4'd2, 0, 8'h00, 4'd2, 1, 8'h99, 0, "R9");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ba, da;
      ba = ($urandom % 4 != 0) ? 4'($urandom % 5) : 4'($urandom % 16);
      da = ($urandom % 2 != 0) ? 4'd4 : 4'($urandom % 16);
      step(ba, 1'($urandom % 3 != 0), 8'($urandom), da, 1'($urandom % 4 == 0),
           8'($urandom), 1'($urandom % 10 < 3), "R3");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule